// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes fixed-size interrupt vectors from client logic and stores them in a circular buffer held in system memory. Each vector is eight 32-bit words, so it fills 32 bytes. The block keeps a write pointer counted in bytes. A consumer moves the read pointer by writing a register. Memory traffic goes through a single word-write port with a request/acknowledge handshake. The block writes a vector's words in order and advances the write pointer only once the last word has been acknowledged.

The ring size is a power of two and is set by a log2 field in the control register. Both pointers wrap by masking. When a vector is stored into a ring that is already full, the block still writes it over the oldest entry. If overflow detection is on, it also sets a sticky flag that lives in bit 0 of the write-pointer register. A strobe bit in the control register clears that flag. When writeback is on, the block writes the write-pointer register value (flag included) as one extra word to a programmable address after every advance. Software can disable the ring and zero both pointers.

Register map, selected by `reg_sel`:
- 0: control.
- 1: base, which holds address bits [39:8].
- 2: read pointer.
- 3: write pointer.
- 4: writeback address low.
- 5: writeback address high.

Top module: `irq_ring_writer`

## Requirements
- R1: After reset `vec_ready` and `mem_req` are 0, and every register reads 0.
- R2: While the ring-enable bit (control bit 0) is 0 and the block is idle, `vec_ready` stays 0 and no memory write is issued.
- R3: An accepted vector is written as eight word writes, word 0 (`vec_data[31:0]`) first. Word i goes to address `{base,8'h00} + wptr + 4*i`. Each request holds its address and data until `mem_ack`.
- R4: After the eighth word is acknowledged, the write pointer becomes `(wptr+32) mod 2^(S+2)` bytes. S is control bits [9:5], clamped to the range 4..MAX_LOG2. Reading register 3 returns the byte pointer, with bits [4:1] always 0.
- R5: If `(wptr+32) mod ring_bytes` equals the read pointer modulo the ring size when a vector completes, and overflow detection (control bit 2) is 1, the block sets bit 0 of register 3. The vector is still written and the pointer still advances. Once set, the flag stays set.
- R6: With control bit 2 at 0, a vector stored into a full ring leaves the flag at 0.
- R7: Writing control with bit 4 set clears the flag. Bit 4 always reads 0.
- R8: With control bit 3 at 1, each pointer advance is followed by one word write of the register-3 value to `{wbhi[7:0], wblo[31:2], 2'b00}`. With bit 3 at 0, no such write is made.
- R9: Writing registers 2 or 3 loads the pointer, and bits [4:0] of the written value are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector accepted when high with `vec_valid` |
| vec_data | input | 256 | Vector, word i in bits [32i+31:32i] |
| mem_req | output | 1 | Memory word-write request |
| mem_ack | input | 1 | Memory write accepted |
| mem_addr | output | 40 | Byte address of the word |
| mem_data | output | 32 | Word to write |

## Verification
The bench drives vectors until the ring wraps and places the read pointer exactly one vector ahead. A design with an off-by-one full test would set the overflow flag one vector early or late. One that stopped advancing on overflow would leave the pointer stuck. The bench compares every acknowledged memory word, in order, against expected addresses and data, under stalled acknowledges. A word-order or stride error, a missing writeback, or a writeback issued while disabled therefore shows as a mismatch or an unexpected write. It also exercises the size clamp, the ring-size change that moves the wrap point, alignment on pointer loads, and the clear strobe. A design that ignored any of these would read back a wrong pointer value.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;
    localparam int WORD_W    = 32;
    localparam int VEC_WORDS = 8;
    localparam int VEC_W     = WORD_W * VEC_WORDS;
    localparam int VEC_BYTES = VEC_WORDS * 4;
    localparam int IDX_W     = $clog2(VEC_WORDS);
    localparam int ADDR_W    = 40;
    localparam int MIN_LOG2  = 4;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_BASE = 3'd1;
    localparam logic [2:0] SEL_RPTR = 3'd2;
    localparam logic [2:0] SEL_WPTR = 3'd3;
    localparam logic [2:0] SEL_WBLO = 3'd4;
    localparam logic [2:0] SEL_WBHI = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_WB   = 2'd2
    } wr_state_e;
endpackage

// File: rtl/irq_ring_ptr.sv
module irq_ring_ptr
    import irq_ring_pkg::*;
#(
    parameter int MAX_LOG2 = 16,
    localparam int PTR_W   = MAX_LOG2 + 2
) (
    input  logic [4:0]       size_log2,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] wptr_adv,
    output logic             full
);
    logic [4:0]       eff_log2;
    logic [PTR_W-1:0] mask;

    always_comb begin
        if (size_log2 < 5'(MIN_LOG2)) begin
            eff_log2 = 5'(MIN_LOG2);
        end else if (size_log2 > 5'(MAX_LOG2)) begin
            eff_log2 = 5'(MAX_LOG2);
        end else begin
            eff_log2 = size_log2;
        end
        mask     = {PTR_W{1'b1}} >> (5'(MAX_LOG2) - eff_log2);
        wptr_adv = (wptr + PTR_W'(VEC_BYTES)) & mask;
        full     = (wptr_adv == (rptr & mask));
    end
endmodule

// File: rtl/irq_ring_ctrl.sv
module irq_ring_ctrl
    import irq_ring_pkg::*;
#(
    parameter int MAX_LOG2 = 16,
    localparam int PTR_W   = MAX_LOG2 + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_sel,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                vec_valid,
    output logic                vec_ready,
    input  logic [VEC_W-1:0]    vec_data,
    output logic                mem_req,
    input  logic                mem_ack,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_data,
    input  logic [PTR_W-1:0]    wptr_adv,
    input  logic                full,
    output logic [PTR_W-1:0]    wptr_o,
    output logic [PTR_W-1:0]    rptr_o,
    output logic [4:0]          size_o,
    output logic                ring_en_o,
    output logic                ovf_o,
    output logic                vec_done_o,
    output logic                ovf_clr_o,
    output logic                wptr_load_o
);
    typedef struct packed {
        wr_state_e          st;
        logic [IDX_W-1:0]   idx;
        logic [VEC_W-1:0]   vbuf;
        logic               ring_en;
        logic               intr_en;
        logic               ovf_en;
        logic               wb_en;
        logic [4:0]         size;
        logic [WORD_W-1:0]  base;
        logic [PTR_W-1:0]   rptr;
        logic [PTR_W-1:0]   wptr;
        logic               ovf;
        logic [ADDR_W-3:0]  wb_addr;
    } ring_regs_t;

    ring_regs_t regs_d, regs_q;
    logic [WORD_W-1:0] wptr_val;
    logic              done_d;

    assign wptr_val    = WORD_W'(regs_q.wptr) | WORD_W'(regs_q.ovf);
    assign ovf_clr_o   = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[4];
    assign wptr_load_o = reg_wr && (reg_sel == SEL_WPTR);
    assign vec_ready   = (regs_q.st == ST_IDLE) && regs_q.ring_en;
    assign mem_req     = (regs_q.st != ST_IDLE);

    always_comb begin
        regs_d = regs_q;
        done_d = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (vec_valid && vec_ready) begin
                    regs_d.vbuf = vec_data;
                    regs_d.idx  = '0;
                    regs_d.st   = ST_VEC;
                end
            end
            ST_VEC: begin
                if (mem_ack) begin
                    if (regs_q.idx == IDX_W'(VEC_WORDS - 1)) begin
                        regs_d.wptr = wptr_adv;
                        if (full && regs_q.ovf_en) begin
                            regs_d.ovf = 1'b1;
                        end
                        done_d    = 1'b1;
                        regs_d.st = regs_q.wb_en ? ST_WB : ST_IDLE;
                    end else begin
                        regs_d.idx = regs_q.idx + 1'b1;
                    end
                end
            end
            ST_WB: begin
                if (mem_ack) begin
                    regs_d.st = ST_IDLE;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
        if (reg_wr) begin
            unique case (reg_sel)
                SEL_CTRL: begin
                    regs_d.ring_en = reg_wdata[0];
                    regs_d.intr_en = reg_wdata[1];
                    regs_d.ovf_en  = reg_wdata[2];
                    regs_d.wb_en   = reg_wdata[3];
                    regs_d.size    = reg_wdata[9:5];
                end
                SEL_BASE: regs_d.base = reg_wdata;
                SEL_RPTR: regs_d.rptr = {reg_wdata[PTR_W-1:5], 5'b0};
                SEL_WPTR: regs_d.wptr = {reg_wdata[PTR_W-1:5], 5'b0};
                SEL_WBLO: regs_d.wb_addr[ADDR_W-11:0] = reg_wdata[WORD_W-1:2];
                SEL_WBHI: regs_d.wb_addr[ADDR_W-3:ADDR_W-10] = reg_wdata[7:0];
                default: ;
            endcase
        end
        if (ovf_clr_o) begin
            regs_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (regs_q.st == ST_WB) begin
            mem_addr = {regs_q.wb_addr, 2'b00};
            mem_data = wptr_val;
        end else begin
            mem_addr = {regs_q.base, 8'h00} + ADDR_W'(regs_q.wptr)
                     + ADDR_W'({regs_q.idx, 2'b00});
            mem_data = regs_q.vbuf[regs_q.idx*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = {22'b0, regs_q.size, 1'b0, regs_q.wb_en,
                                   regs_q.ovf_en, regs_q.intr_en, regs_q.ring_en};
            SEL_BASE: reg_rdata = regs_q.base;
            SEL_RPTR: reg_rdata = WORD_W'(regs_q.rptr);
            SEL_WPTR: reg_rdata = wptr_val;
            SEL_WBLO: reg_rdata = {regs_q.wb_addr[ADDR_W-11:0], 2'b00};
            SEL_WBHI: reg_rdata = {24'b0, regs_q.wb_addr[ADDR_W-3:ADDR_W-10]};
            default:  reg_rdata = '0;
        endcase
    end

    assign wptr_o     = regs_q.wptr;
    assign rptr_o     = regs_q.rptr;
    assign size_o     = regs_q.size;
    assign ring_en_o  = regs_q.ring_en;
    assign ovf_o      = regs_q.ovf;
    assign vec_done_o = done_d;
endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
    import irq_ring_pkg::*;
#(
    parameter int MAX_LOG2 = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_sel,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                vec_valid,
    output logic                vec_ready,
    input  logic [VEC_W-1:0]    vec_data,
    output logic                mem_req,
    input  logic                mem_ack,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_data
);
    localparam int PTR_W = MAX_LOG2 + 2;

    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;
    logic [PTR_W-1:0] wptr_adv;
    logic [4:0]       size_q;
    logic             full;
    logic             ring_en;
    logic             ovf_flag;
    logic             vec_done;
    logic             ovf_clr;
    logic             wptr_load;

    irq_ring_ptr #(.MAX_LOG2(MAX_LOG2)) u_ptr (
        .size_log2 (size_q),
        .wptr      (wptr_q),
        .rptr      (rptr_q),
        .wptr_adv  (wptr_adv),
        .full      (full)
    );

    irq_ring_ctrl #(.MAX_LOG2(MAX_LOG2)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .vec_valid   (vec_valid),
        .vec_ready   (vec_ready),
        .vec_data    (vec_data),
        .mem_req     (mem_req),
        .mem_ack     (mem_ack),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data),
        .wptr_adv    (wptr_adv),
        .full        (full),
        .wptr_o      (wptr_q),
        .rptr_o      (rptr_q),
        .size_o      (size_q),
        .ring_en_o   (ring_en),
        .ovf_o       (ovf_flag),
        .vec_done_o  (vec_done),
        .ovf_clr_o   (ovf_clr),
        .wptr_load_o (wptr_load)
    );
endmodule

// File: rtl/irq_ring_writer_chk.sv
module irq_ring_writer_chk #(
    parameter int MAX_LOG2 = 16,
    localparam int PTR_W   = MAX_LOG2 + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [39:0]      mem_addr,
    input logic [31:0]      mem_data,
    input logic             ring_en,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic             vec_done,
    input logic             wptr_load,
    input logic [PTR_W-1:0] wptr_q
);
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

    a_r2_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_en && !mem_req) |=> !mem_req);

    a_r4_wptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_q[4:0] == 5'd0);

    a_r4_wptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_done && !wptr_load) |=> $stable(wptr_q));

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> !ovf_flag);
endmodule

bind irq_ring_writer irq_ring_writer_chk #(.MAX_LOG2(MAX_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .ring_en   (ring_en),
    .ovf_flag  (ovf_flag),
    .ovf_clr   (ovf_clr),
    .vec_done  (vec_done),
    .wptr_load (wptr_load),
    .wptr_q    (wptr_q)
);

// File: tb/irq_ring_writer_tb.sv
module irq_ring_writer_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_sel = 3'd3;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         vec_valid = 1'b0;
    logic         vec_ready;
    logic [255:0] vec_data = '0;
    logic         mem_req;
    logic         mem_ack = 1'b0;
    logic [39:0]  mem_addr;
    logic [31:0]  mem_data;

    int total = 0;
    int bad = 0;
    int ack_cnt = 0;
    logic [71:0] exp_q[$];

    // behavioural model state
    logic [31:0] m_ctrl = 0, m_base = 0, m_wblo = 0, m_wbhi = 0;
    int unsigned m_wptr = 0, m_rptr = 0;
    bit m_ovf = 0;

    irq_ring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_valid(vec_valid),
        .vec_ready(vec_ready), .vec_data(vec_data), .mem_req(mem_req),
        .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory port: stalled acknowledge, every transfer compared in order
    always @(negedge clk) begin
        ack_cnt++;
        mem_ack = mem_req && (ack_cnt % 3 != 0);
        if (mem_req && mem_ack) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3/R8 unexpected write actual=%h expected=none", {mem_addr, mem_data});
            end else begin
                check("R3/R8 memory word", {mem_addr, mem_data}, exp_q.pop_front());
            end
        end
    end

    // per-clock comparison of the write pointer register while quiet
    always @(posedge clk) begin
        #3;
        if (rst_n && !mem_req && exp_q.size() == 0 && reg_sel == 3'd3 && !reg_wr)
            check("R4 wptr per clock", 72'(reg_rdata), 72'(m_wptr | m_ovf));
    end

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        case (sel)
            3'd0: begin m_ctrl = d & ~32'h10; if (d[4]) m_ovf = 0; end
            3'd1: m_base = d;
            3'd2: m_rptr = d & 32'h3_FFE0;
            3'd3: m_wptr = d & 32'h3_FFE0;
            3'd4: m_wblo = d;
            3'd5: m_wbhi = d & 32'hFF;
            default: ;
        endcase
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 3'd3;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel; #1; v = reg_rdata; reg_sel = 3'd3;
    endtask

    function automatic logic [255:0] make_vec(input int seed);
        logic [255:0] v;
        for (int k = 0; k < 8; k++)
            v[32*k +: 32] = (32'(seed) * 32'h0101_0101) ^ (32'(k) << 28) ^ 32'(k * 7);
        return v;
    endfunction

    task automatic model_vec(input logic [255:0] d);
        int unsigned s, mask, adv;
        s = m_ctrl[9:5];
        if (s < 4) s = 4;
        if (s > 16) s = 16;
        mask = (1 << (s + 2)) - 1;
        for (int i = 0; i < 8; i++)
            exp_q.push_back({{m_base, 8'h00} + 40'(m_wptr) + 40'(4 * i), d[32*i +: 32]});
        adv = (m_wptr + 32) & mask;
        if (adv == (m_rptr & mask) && m_ctrl[2]) m_ovf = 1;
        m_wptr = adv;
        if (m_ctrl[3])
            exp_q.push_back({m_wbhi[7:0], m_wblo[31:2], 2'b00, 32'(m_wptr | m_ovf)});
    endtask

    task automatic send_vec(input int seed);
        logic [255:0] d;
        d = make_vec(seed);
        @(negedge clk);
        vec_data = d; vec_valid = 1'b1;
        #1;
        while (!vec_ready) begin @(negedge clk); #1; end
        model_vec(d);
        @(negedge clk);
        vec_valid = 1'b0;
        do begin @(negedge clk); #2; end while (exp_q.size() != 0 || mem_req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            reg_read(3'(s), v);
            check("R1 register reset", 72'(v), 72'd0);
        end
        check("R1 vec_ready reset", 72'(vec_ready), 72'd0);
        check("R1 mem_req reset", 72'(mem_req), 72'd0);

        // R2 vectors refused while disabled
        reg_write(3'd1, 32'h0001_2345);
        reg_write(3'd4, 32'h0000_8000);
        reg_write(3'd5, 32'h0000_005A);
        reg_write(3'd0, 32'h0000_00AC);
        @(negedge clk); vec_data = make_vec(99); vec_valid = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk); #1;
            check("R2 vec_ready while disabled", 72'(vec_ready), 72'd0);
        end
        vec_valid = 1'b0;
        check("R2 no request while disabled", 72'(mem_req), 72'd0);

        // R3 R4 R8 normal writes, ring of 128 bytes
        reg_write(3'd0, 32'h0000_00AD);
        send_vec(1); reg_read(3'd3, v); check("R4 wptr after 1", 72'(v), 72'd32);
        send_vec(2); reg_read(3'd3, v); check("R4 wptr after 2", 72'(v), 72'd64);
        send_vec(3); reg_read(3'd3, v); check("R4 wptr after 3", 72'(v), 72'd96);

        // R5 full ring: wraps to 0 and sets the flag
        send_vec(4); reg_read(3'd3, v); check("R5 overflow wrap", 72'(v), 72'd1);

        // R7 clear strobe
        reg_write(3'd0, 32'h0000_00BD);
        reg_read(3'd3, v); check("R7 flag cleared", 72'(v), 72'd0);
        reg_read(3'd0, v); check("R7 strobe reads 0", 72'(v), 72'h0AD);

        // R6 detection off
        reg_write(3'd0, 32'h0000_00A9);
        reg_write(3'd2, 32'h0000_0020);
        send_vec(5); reg_read(3'd3, v); check("R6 no flag when off", 72'(v), 72'd32);

        // R8 writeback off, R5 again with read pointer ahead
        reg_write(3'd0, 32'h0000_00A5);
        reg_write(3'd2, 32'h0000_0040);
        send_vec(6);
        repeat (4) @(negedge clk);
        #1 check("R8 no writeback when off", 72'(mem_req), 72'd0);
        reg_read(3'd3, v); check("R5 flag with rptr ahead", 72'(v), 72'd65);

        // R4 larger ring moves the wrap point
        reg_write(3'd0, 32'h0000_00B5);
        reg_read(3'd3, v); check("R7 clear again", 72'(v), 72'd64);
        reg_write(3'd0, 32'h0000_00CD);
        reg_write(3'd3, 32'h0000_00E0);
        reg_write(3'd2, 32'h0000_0020);
        send_vec(7); reg_read(3'd3, v); check("R4 wrap at 256 bytes", 72'(v), 72'd0);

        // R9 pointer load ignores low bits
        reg_write(3'd3, 32'h0000_0047);
        reg_read(3'd3, v); check("R9 wptr load aligned", 72'(v), 72'h40);
        reg_write(3'd2, 32'h0000_013F);
        reg_read(3'd2, v); check("R9 rptr load aligned", 72'(v), 72'h120);

        // R4 size field clamped up to 64 bytes
        reg_write(3'd0, 32'h0000_0049);
        reg_write(3'd3, 32'h0000_0020);
        reg_write(3'd2, 32'h0000_0000);
        send_vec(8); reg_read(3'd3, v); check("R4 size clamp", 72'(v), 72'd0);

        // R2 R9 disable and zero pointers
        reg_write(3'd0, 32'h0000_0000);
        reg_write(3'd2, 32'h0000_0000);
        reg_write(3'd3, 32'h0000_0000);
        @(negedge clk); #1;
        check("R2 ready low after disable", 72'(vec_ready), 72'd0);
        reg_read(3'd3, v); check("R9 wptr zeroed", 72'(v), 72'd0);
        reg_read(3'd2, v); check("R9 rptr zeroed", 72'(v), 72'd0);
        check("R3 no leftover writes", 72'(exp_q.size()), 72'd0);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule